// File: doc/BRIEF.md
# CEC Transmit Sequencer and Status Core

This block is the control and status heart of a consumer-electronics-control bus controller. It sits between a register front end and a bit-level line engine. It holds the start and end message commands. It passes data bytes from software to the line engine through a one-entry holding stage. It asks software for each next byte, and it enforces a deadline on that request. It turns single-cycle event pulses from the line engine into sticky status flags. Software clears these flags by writing 1 to them.

Transmit events end a message by clearing both command bits. These events are underrun, line conflict, missing acknowledge and normal completion. Lost arbitration is different: it hands the device over to reception and keeps the start command pending, so the controller retries later. The receive-side events are a missing acknowledge and a long bit period. Both abort reception, and a long bit period may also request an error bit on the line.

The data path from software has valid/ready handshakes on both sides. `sw_data_ready` is high whenever the holding stage is empty. A byte is taken on a cycle where both `sw_data_valid` and `sw_data_ready` are high. While a byte is held, `sw_data_ready` stays low, so software must hold its data and keep `sw_data_valid` high. `le_byte_valid` stays high while a byte is held, and the held byte leaves on a cycle where `le_byte_ready` is high.

Top module: `cec_txctl_core`

## Requirements
- R1: Status bit 0 (byte request) sets one cycle after the fourth `ev_bit_sent` pulse of the current byte, while the start command is set and the end command is clear. The bit count restarts every 10 bit pulses, and it also restarts whenever the start command is clear.
- R2: After a byte request, status bit 2 (underrun) sets if 6 `tick_bit` pulses arrive while the holding stage stays empty. Accepting a data byte cancels the deadline, and so does clearing the byte request.
- R3: Underrun, line conflict (status bit 3) and transmit missing acknowledge each clear `cmd_som` and `cmd_eom` in the same cycle as their flag sets, and each gives a one-cycle `tx_abort`. Line conflict is an `ev_conflict` pulse while the start command is set.
- R4: An `ev_ack_slot` pulse with the acknowledge good while `cmd_eom` is set sets status bit 1 (transmission done). It also clears both command bits, and it gives no `tx_abort`.
- R5: Transmit missing acknowledge (status bit 4) sets on `ev_ack_slot` while the start command is set, in two cases. With `bcast` low it sets when `ack_low` is 0. With `bcast` high it sets when `ack_low` is 1 (negative acknowledge).
- R6: An `ev_arb_lost` pulse while the start command is set sets status bit 5 and gives a one-cycle `rx_switch`. It leaves `cmd_som` set and gives no `tx_abort`.
- R7: An `ev_rx_ack_slot` pulse with `ack_low` at 0 sets status bit 6 and gives a one-cycle `rx_abort`, but only in two cases: `bcast` is high, or `listen_en` is high while `own_hit` is low. In every other case it has no effect.
- R8: An `ev_long_bit` pulse sets status bit 7 and gives a one-cycle `rx_abort`. It also gives a one-cycle `err_bit_req` when `lbp_gen_en` or `bcast` is high.
- R9: A `stat_wr` clears each status bit whose `stat_wdata` bit is 1, and zero bits have no effect. A hardware set in the same cycle wins over a clear. `stat_rdata` bits 31 to 8 always read 0.
- R10: `irq` is high whenever any status bit is set together with the matching `irq_en` bit.
- R11: `sw_data_ready` is the inverse of `le_byte_valid`. An accepted byte appears on `le_byte` the next cycle, and it is released when `le_byte_ready` is high.
- R12: `sw_som_set` and `sw_eom_set` set their command bits. An ending event in the same cycle wins over the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_bit | input | 1 | One pulse per nominal bit period |
| sw_som_set | input | 1 | Software sets the start command |
| sw_eom_set | input | 1 | Software sets the end command |
| sw_data_valid | input | 1 | Software data byte valid |
| sw_data_ready | output | 1 | Holding stage empty |
| sw_data | input | 8 | Software data byte |
| le_byte_valid | output | 1 | Held byte valid toward line engine |
| le_byte_ready | input | 1 | Line engine takes the held byte |
| le_byte | output | 8 | Held byte |
| stat_wr | input | 1 | Status write strobe (write 1 to clear) |
| stat_wdata | input | 32 | Status write data |
| stat_rdata | output | 32 | Status flags, bits 31..8 zero |
| irq_en | input | 8 | Per-flag interrupt enable |
| irq | output | 1 | Interrupt request |
| cmd_som | output | 1 | Start command bit |
| cmd_eom | output | 1 | End command bit |
| ev_bit_sent | input | 1 | A transmitted bit finished |
| ev_ack_slot | input | 1 | Transmit acknowledge slot sampled |
| ev_rx_ack_slot | input | 1 | Receive acknowledge slot sampled |
| ack_low | input | 1 | Line was low in the acknowledge slot |
| bcast | input | 1 | Current message is broadcast |
| listen_en | input | 1 | Listen mode enabled |
| own_hit | input | 1 | Destination matches an enabled own address |
| ev_conflict | input | 1 | Line seen low while released |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_long_bit | input | 1 | Long bit period detected |
| lbp_gen_en | input | 1 | Error bit enable for long bit period |
| tx_abort | output | 1 | Transmission abort pulse |
| rx_abort | output | 1 | Reception abort pulse |
| rx_switch | output | 1 | Switch to reception pulse |
| err_bit_req | output | 1 | Request to drive an error bit |

## Verification
Each event shows up at the ports one cycle later: in `stat_rdata`, in the command bits and in a pulse output. So a wrong decode shows one cycle after its stimulus. A bit counter that drifts shows as a byte request that comes one bit pulse early or late, or that also appears with the end command set. A deadline counter that is off by one shows as an underrun after the fifth tick, or a missing one after the sixth. A wrong command clear shows as `cmd_som` in the wrong state right after a conflict or a lost arbitration.

// File: rtl/cec_txctl_pkg.sv
package cec_txctl_pkg;
  localparam int NFLAG    = 8;
  localparam int F_BREQ   = 0;
  localparam int F_DONE   = 1;
  localparam int F_UDR    = 2;
  localparam int F_LERR   = 3;
  localparam int F_TXNACK = 4;
  localparam int F_ARB    = 5;
  localparam int F_RXNACK = 6;
  localparam int F_LBP    = 7;
endpackage

// File: rtl/cec_flag_bank.sv
module cec_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flags[i] <= 1'b0;
      else if (set_ev[i])      flags[i] <= 1'b1;   // set beats clear
      else if (clr_we && clr_mask[i]) flags[i] <= 1'b0;
    end
  end
  assign irq = |(flags & en);
endmodule

// File: rtl/cec_deadline_tmr.sv
module cec_deadline_tmr #(
  parameter int TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign expire = run && tick && (cnt == LAST) && !stop && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (stop) begin
      run <= 1'b0;
    end else if (run && tick) begin
      if (cnt == LAST) run <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cec_cmd_seq.sv
module cec_cmd_seq #(
  parameter int BITS_PER_BYTE = 10,
  parameter int REQ_BIT       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_som_set,
  input  logic sw_eom_set,
  input  logic ev_bit_sent,
  input  logic ev_ack_slot,
  input  logic ack_low,
  input  logic bcast,
  input  logic ev_conflict,
  input  logic ev_arb_lost,
  input  logic udr_ev,
  output logic cmd_som,
  output logic cmd_eom,
  output logic breq_ev,
  output logic done_ev,
  output logic txnack_ev,
  output logic lerr_ev,
  output logic arb_ev,
  output logic tx_abort,
  output logic rx_switch
);
  localparam int BW = $clog2(BITS_PER_BYTE);
  localparam logic [BW-1:0] WRAP = BW'(BITS_PER_BYTE - 1);
  localparam logic [BW-1:0] REQ  = BW'(REQ_BIT - 1);

  logic [BW-1:0] bit_cnt;
  logic          ack_bad, end_all, fail;

  assign ack_bad   = bcast ? ack_low : !ack_low;
  assign txnack_ev = cmd_som && ev_ack_slot && ack_bad;
  assign done_ev   = cmd_som && ev_ack_slot && !ack_bad && cmd_eom;
  assign lerr_ev   = cmd_som && ev_conflict;
  assign arb_ev    = cmd_som && ev_arb_lost;
  assign breq_ev   = cmd_som && !cmd_eom && ev_bit_sent && (bit_cnt == REQ);
  assign fail      = udr_ev || lerr_ev || txnack_ev;
  assign end_all   = fail || done_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            bit_cnt <= '0;
    else if (!cmd_som)     bit_cnt <= '0;
    else if (ev_bit_sent)  bit_cnt <= (bit_cnt == WRAP) ? '0 : bit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_som   <= 1'b0;
      cmd_eom   <= 1'b0;
      tx_abort  <= 1'b0;
      rx_switch <= 1'b0;
    end else begin
      tx_abort  <= fail;
      rx_switch <= arb_ev;
      if (end_all) begin
        cmd_som <= 1'b0;
        cmd_eom <= 1'b0;
      end else begin
        if (sw_som_set) cmd_som <= 1'b1;
        if (sw_eom_set) cmd_eom <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cec_rx_evt.sv
module cec_rx_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_rx_ack_slot,
  input  logic ack_low,
  input  logic bcast,
  input  logic listen_en,
  input  logic own_hit,
  input  logic ev_long_bit,
  input  logic lbp_gen_en,
  output logic rxnack_ev,
  output logic lbp_ev,
  output logic rx_abort,
  output logic err_bit_req
);
  logic watched;
  assign watched   = bcast || (listen_en && !own_hit);
  assign rxnack_ev = ev_rx_ack_slot && !ack_low && watched;
  assign lbp_ev    = ev_long_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_abort    <= 1'b0;
      err_bit_req <= 1'b0;
    end else begin
      rx_abort    <= rxnack_ev || lbp_ev;
      err_bit_req <= lbp_ev && (lbp_gen_en || bcast);
    end
  end
endmodule

// File: rtl/cec_txctl_core.sv
module cec_txctl_core
  import cec_txctl_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int REG_W          = 32,
  parameter int BITS_PER_BYTE  = 10,
  parameter int REQ_BIT        = 4,
  parameter int DEADLINE_TICKS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_bit,
  input  logic              sw_som_set,
  input  logic              sw_eom_set,
  input  logic              sw_data_valid,
  output logic              sw_data_ready,
  input  logic [DATA_W-1:0] sw_data,
  output logic              le_byte_valid,
  input  logic              le_byte_ready,
  output logic [DATA_W-1:0] le_byte,
  input  logic              stat_wr,
  input  logic [REG_W-1:0]  stat_wdata,
  output logic [REG_W-1:0]  stat_rdata,
  input  logic [NFLAG-1:0]  irq_en,
  output logic              irq,
  output logic              cmd_som,
  output logic              cmd_eom,
  input  logic              ev_bit_sent,
  input  logic              ev_ack_slot,
  input  logic              ev_rx_ack_slot,
  input  logic              ack_low,
  input  logic              bcast,
  input  logic              listen_en,
  input  logic              own_hit,
  input  logic              ev_conflict,
  input  logic              ev_arb_lost,
  input  logic              ev_long_bit,
  input  logic              lbp_gen_en,
  output logic              tx_abort,
  output logic              rx_abort,
  output logic              rx_switch,
  output logic              err_bit_req
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_q;
  logic              sw_fire, le_fire;
  logic              breq_ev, done_ev, txnack_ev, lerr_ev, arb_ev, udr_ev;
  logic              rxnack_ev, lbp_ev, tmr_expire, tmr_stop, cmd_end;
  logic [NFLAG-1:0]  set_ev, flags;
  logic              unused_hi;

  assign unused_hi     = ^stat_wdata[REG_W-1:NFLAG];
  assign sw_data_ready = !hold_full;
  assign le_byte_valid = hold_full;
  assign le_byte       = hold_q;
  assign sw_fire       = sw_data_valid && sw_data_ready;
  assign le_fire       = le_byte_valid && le_byte_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (sw_fire) begin
      hold_full <= 1'b1;
      hold_q    <= sw_data;
    end else if (le_fire) begin
      hold_full <= 1'b0;
    end
  end

  cec_cmd_seq #(.BITS_PER_BYTE(BITS_PER_BYTE), .REQ_BIT(REQ_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sw_som_set(sw_som_set), .sw_eom_set(sw_eom_set),
    .ev_bit_sent(ev_bit_sent), .ev_ack_slot(ev_ack_slot),
    .ack_low(ack_low), .bcast(bcast),
    .ev_conflict(ev_conflict), .ev_arb_lost(ev_arb_lost), .udr_ev(udr_ev),
    .cmd_som(cmd_som), .cmd_eom(cmd_eom),
    .breq_ev(breq_ev), .done_ev(done_ev), .txnack_ev(txnack_ev),
    .lerr_ev(lerr_ev), .arb_ev(arb_ev),
    .tx_abort(tx_abort), .rx_switch(rx_switch)
  );

  assign cmd_end  = lerr_ev || txnack_ev || done_ev;
  assign tmr_stop = sw_fire || (stat_wr && stat_wdata[F_BREQ]) || cmd_end;
  assign udr_ev   = tmr_expire && !hold_full;

  cec_deadline_tmr #(.TICKS(DEADLINE_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start(breq_ev), .stop(tmr_stop), .tick(tick_bit),
    .expire(tmr_expire)
  );

  cec_rx_evt u_rx (
    .clk(clk), .rst_n(rst_n),
    .ev_rx_ack_slot(ev_rx_ack_slot), .ack_low(ack_low), .bcast(bcast),
    .listen_en(listen_en), .own_hit(own_hit),
    .ev_long_bit(ev_long_bit), .lbp_gen_en(lbp_gen_en),
    .rxnack_ev(rxnack_ev), .lbp_ev(lbp_ev),
    .rx_abort(rx_abort), .err_bit_req(err_bit_req)
  );

  always_comb begin
    set_ev           = '0;
    set_ev[F_BREQ]   = breq_ev;
    set_ev[F_DONE]   = done_ev;
    set_ev[F_UDR]    = udr_ev;
    set_ev[F_LERR]   = lerr_ev;
    set_ev[F_TXNACK] = txnack_ev;
    set_ev[F_ARB]    = arb_ev;
    set_ev[F_RXNACK] = rxnack_ev;
    set_ev[F_LBP]    = lbp_ev;
  end

  cec_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_ev(set_ev), .clr_we(stat_wr), .clr_mask(stat_wdata[NFLAG-1:0]),
    .en(irq_en), .flags(flags), .irq(irq)
  );

  assign stat_rdata = {{(REG_W-NFLAG){1'b0}}, flags};
endmodule

// File: rtl/cec_txctl_chk.sv
module cec_txctl_chk
  import cec_txctl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] stat_rdata,
  input logic             stat_wr,
  input logic [REG_W-1:0] stat_wdata,
  input logic             cmd_som,
  input logic             cmd_eom,
  input logic             ev_arb_lost,
  input logic             ev_conflict,
  input logic             ev_ack_slot,
  input logic             tick_bit,
  input logic             ev_long_bit,
  input logic             lbp_gen_en,
  input logic             bcast,
  input logic             err_bit_req,
  input logic             tx_abort,
  input logic             sw_data_valid,
  input logic             sw_data_ready
);
  // R6
  arb_keeps_som_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_som && ev_arb_lost && !ev_conflict && !ev_ack_slot && !tick_bit) |=> cmd_som);

  // R3
  udr_clears_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[F_UDR]) |-> (!cmd_som && !cmd_eom));

  // R3
  conflict_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_som && ev_conflict) |=> (tx_abort && !cmd_som));

  // R8
  lbp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_long_bit && (lbp_gen_en || bcast)) |=> err_bit_req);

  // R9
  w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((($past(stat_rdata) & ~$past(stat_wdata)) & ~stat_rdata) == '0));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[REG_W-1:NFLAG] == '0);

  // R11
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_data_valid && sw_data_ready) |=> !sw_data_ready);
endmodule

bind cec_txctl_core cec_txctl_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rdata(stat_rdata), .stat_wr(stat_wr),
  .stat_wdata(stat_wdata), .cmd_som(cmd_som), .cmd_eom(cmd_eom),
  .ev_arb_lost(ev_arb_lost), .ev_conflict(ev_conflict), .ev_ack_slot(ev_ack_slot),
  .tick_bit(tick_bit), .ev_long_bit(ev_long_bit), .lbp_gen_en(lbp_gen_en),
  .bcast(bcast), .err_bit_req(err_bit_req), .tx_abort(tx_abort),
  .sw_data_valid(sw_data_valid), .sw_data_ready(sw_data_ready)
);

// File: tb/tb_cec_txctl_core.sv
module tb_cec_txctl_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic tick_bit = 0, sw_som_set = 0, sw_eom_set = 0, sw_data_valid = 0;
  logic sw_data_ready, le_byte_valid, le_byte_ready = 0;
  logic [7:0] sw_data = 0, le_byte;
  logic stat_wr = 0;
  logic [31:0] stat_wdata = 0, stat_rdata;
  logic [7:0] irq_en = 0;
  logic irq, cmd_som, cmd_eom;
  logic ev_bit_sent = 0, ev_ack_slot = 0, ev_rx_ack_slot = 0, ack_low = 0;
  logic bcast = 0, listen_en = 0, own_hit = 0, ev_conflict = 0;
  logic ev_arb_lost = 0, ev_long_bit = 0, lbp_gen_en = 0;
  logic tx_abort, rx_abort, rx_switch, err_bit_req;

  cec_txctl_core dut (.*);

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  event chk_ev;

  // sel: 0 status, 1 {som,eom}, 2 {tx_abort,rx_abort,err_bit_req,rx_switch},
  //      3 irq, 4 {sw_data_ready,le_byte_valid}, 5 le_byte
  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return stat_rdata;
      1: return {30'd0, cmd_som, cmd_eom};
      2: return {28'd0, tx_abort, rx_abort, err_bit_req, rx_switch};
      3: return {31'd0, irq};
      4: return {30'd0, sw_data_ready, le_byte_valid};
      default: return {24'd0, le_byte};
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(chk_ev);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int sel, logic [31:0] e, string req);
    item_t it;
    it.sel = sel; it.exp = e; it.req = req;
    q.push_back(it);
  endtask

  task automatic flush();
    ->chk_ev;
    #2;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic bits(int n);
    for (int i = 0; i < n; i++) begin
      ev_bit_sent = 1; step(); ev_bit_sent = 0;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_bit = 1; step(); tick_bit = 0;
    end
  endtask

  task automatic clr(logic [31:0] m);
    stat_wr = 1; stat_wdata = m; step(); stat_wr = 0; stat_wdata = 0;
  endtask

  task automatic som();
    sw_som_set = 1; step(); sw_som_set = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) step();
    rst_n = 1;
    step();
    expect_val(0, 32'h0, "R9 reset status");
    expect_val(1, 32'h0, "R12 reset cmds");
    expect_val(2, 32'h0, "R3 reset pulses");
    expect_val(4, 32'h2, "R11 reset ready");
    flush();

    // R11 data stream
    sw_data = 8'hA5; sw_data_valid = 1; step(); sw_data_valid = 0;
    expect_val(4, 32'h1, "R11 held byte");
    expect_val(5, 32'hA5, "R11 held value");
    flush();
    le_byte_ready = 1; step(); le_byte_ready = 0;
    expect_val(4, 32'h2, "R11 released");
    flush();

    // R1 byte request
    som();
    expect_val(1, 32'h2, "R12 som set");
    flush();
    bits(3);
    expect_val(0, 32'h0, "R1 no request after 3 bits");
    flush();
    bits(1);
    expect_val(0, 32'h1, "R1 request after 4th bit");
    flush();

    // R2 data write cancels deadline
    sw_data = 8'h3C; sw_data_valid = 1; step(); sw_data_valid = 0;
    ticks(8);
    expect_val(0, 32'h1, "R2 no underrun after data");
    expect_val(1, 32'h2, "R2 cmd kept");
    flush();
    clr(32'h0000_00FE);
    expect_val(0, 32'h1, "R9 zero bits keep flag");
    flush();
    clr(32'h1);
    expect_val(0, 32'h0, "R9 w1c clears");
    flush();
    le_byte_ready = 1; step(); le_byte_ready = 0;
    bits(6);
    bits(4);
    expect_val(0, 32'h1, "R1 request on next byte");
    flush();
    ticks(5);
    expect_val(0, 32'h1, "R2 no underrun after 5 ticks");
    flush();
    ticks(1);
    expect_val(0, 32'h5, "R2 underrun after 6 ticks");
    expect_val(1, 32'h0, "R3 underrun clears cmds");
    expect_val(2, 32'h8, "R3 underrun abort");
    flush();
    clr(32'hFFFF_FFFF);
    expect_val(0, 32'h0, "R9 clear all");
    flush();

    // R1 no request with eom set
    sw_som_set = 1; sw_eom_set = 1; step(); sw_som_set = 0; sw_eom_set = 0;
    expect_val(1, 32'h3, "R12 som and eom set");
    flush();
    bits(4);
    expect_val(0, 32'h0, "R1 no request when eom set");
    flush();

    // R4 done
    irq_en = 8'h02;
    ack_low = 1; ev_ack_slot = 1; step(); ev_ack_slot = 0; ack_low = 0;
    expect_val(0, 32'h2, "R4 done flag");
    expect_val(1, 32'h0, "R4 cmds cleared");
    expect_val(2, 32'h0, "R4 no abort");
    expect_val(3, 32'h1, "R10 irq enabled");
    flush();
    irq_en = 8'h01;
    step();
    expect_val(3, 32'h0, "R10 irq masked");
    flush();
    clr(32'hFF);

    // R5 nack addressed
    som();
    ack_low = 0; ev_ack_slot = 1; step(); ev_ack_slot = 0;
    expect_val(0, 32'h10, "R5 addressed nack");
    expect_val(1, 32'h0, "R3 nack clears cmds");
    expect_val(2, 32'h8, "R3 nack abort");
    flush();
    clr(32'hFF);
    som();
    bcast = 1; ack_low = 1; ev_ack_slot = 1; step(); ev_ack_slot = 0; ack_low = 0; bcast = 0;
    expect_val(0, 32'h10, "R5 broadcast negative ack");
    flush();
    clr(32'hFF);

    // R3 conflict
    som();
    ev_conflict = 1; step(); ev_conflict = 0;
    expect_val(0, 32'h08, "R3 line error flag");
    expect_val(1, 32'h0, "R3 conflict clears cmds");
    expect_val(2, 32'h8, "R3 conflict abort");
    flush();
    clr(32'hFF);

    // R6 arbitration lost
    som();
    ev_arb_lost = 1; step(); ev_arb_lost = 0;
    expect_val(0, 32'h20, "R6 arb flag");
    expect_val(1, 32'h2, "R6 som kept");
    expect_val(2, 32'h1, "R6 rx switch only");
    flush();
    clr(32'hFF);

    // R12 clear wins over set
    ev_conflict = 1; sw_eom_set = 1; step(); ev_conflict = 0; sw_eom_set = 0;
    expect_val(1, 32'h0, "R12 clear beats set");
    flush();
    clr(32'hFF);

    // R7 receive nack
    ack_low = 0; ev_rx_ack_slot = 1; step(); ev_rx_ack_slot = 0;
    expect_val(0, 32'h0, "R7 directed not watched ignored");
    expect_val(2, 32'h0, "R7 no rx abort");
    flush();
    listen_en = 1; own_hit = 1; ev_rx_ack_slot = 1; step(); ev_rx_ack_slot = 0;
    expect_val(0, 32'h0, "R7 own address ignored");
    flush();
    own_hit = 0; ev_rx_ack_slot = 1; step(); ev_rx_ack_slot = 0; listen_en = 0;
    expect_val(0, 32'h40, "R7 listen nack");
    expect_val(2, 32'h4, "R7 rx abort");
    flush();
    clr(32'hFF);
    bcast = 1; ev_rx_ack_slot = 1; step(); ev_rx_ack_slot = 0; bcast = 0;
    expect_val(0, 32'h40, "R7 broadcast nack");
    flush();
    clr(32'hFF);

    // R8 long bit
    ev_long_bit = 1; step(); ev_long_bit = 0;
    expect_val(0, 32'h80, "R8 long bit flag");
    expect_val(2, 32'h4, "R8 abort no error bit");
    flush();
    lbp_gen_en = 1; ev_long_bit = 1; step(); ev_long_bit = 0; lbp_gen_en = 0;
    expect_val(2, 32'h6, "R8 error bit when enabled");
    flush();
    bcast = 1; ev_long_bit = 1; step(); ev_long_bit = 0; bcast = 0;
    expect_val(2, 32'h6, "R8 error bit on broadcast");
    flush();

    // R9 set wins, upper zero
    stat_wr = 1; stat_wdata = 32'h80; ev_long_bit = 1; step();
    stat_wr = 0; stat_wdata = 0; ev_long_bit = 0;
    expect_val(0, 32'h80, "R9 set beats clear");
    flush();
    clr(32'hFFFF_FF00);
    expect_val(0, 32'h80, "R9 upper bits zero and no effect");
    flush();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule